// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits beside the page loader of a word-wide flash-style memory and watches every host write strobe (address and data). It recognises short "magic" write sequences of three and six steps and turns them into mode changes: arming write protection while opening a page-load window, dropping protection, launching a whole-array erase, and entering or leaving an identification read mode. For each strobe it raises a qualifier that tells the page loader whether that word may be taken into the page buffer.

While protection is armed, a word reaches the page buffer only if the three-step arm sequence came just before it, with each write following the previous one within a load-cycle timeout. When protection is off, every write is passed. In identification mode, reads of the two lowest addresses return a maker code and a part code, both given as parameters. The erase itself and keeping the protect state across power loss are handled elsewhere. Here the protect state is a register that comes out of reset armed.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After reset, protect_on is 1, id_mode is 0, erase_req is 0 and no sequence is in progress.
- R2: Three writes, 16'hAAAA to 5555, 16'h5555 to 2AAA and 16'hA0A0 to 5555, set protect_on to 1 and open the page-load window from the next cycle. The third write itself is not passed, and a later write inside the window is passed.
- R3: While protect_on is 1 and the window is closed, wr_permit stays 0 on every strobe.
- R4: The window stays open while each write comes at most TIMEOUT cycles after the previous one, counted strobe to strobe. A gap of TIMEOUT+1 cycles closes it.
- R5: Six writes, AAAA@5555, 5555@2AAA, 8080@5555, AAAA@5555, 5555@2AAA, 2020@5555, clear protect_on. After that, every strobe has wr_permit 1.
- R6: The same five-write prefix ending in 1010@5555 makes erase_req high for exactly the one cycle after the sixth write, and leaves protect_on unchanged.
- R7: id_mode is set by the five-write prefix ending in 6060@5555, or by AAAA@5555, 5555@2AAA, 9090@5555. It is cleared by AAAA@5555, 5555@2AAA, F0F0@5555.
- R8: With id_mode at 1, id_rdata is MFR_CODE when rd_addr bits 14..0 equal 0, DEV_CODE when they equal 1, and 0 otherwise. With id_mode at 0, id_rdata is 0.
- R9: Only address bits 14..0 take part in matching, so bit 15 of wr_addr has no effect.
- R10: A write that is not the expected next step ends the sequence in progress. That same write is then tested as a first step, so AAAA@5555 repeated still begins a new sequence.
- R11: If a step comes more than TIMEOUT cycles after the previous write, the partial sequence is dropped and that write starts over from idle.
- R12: A sequence whose last write carries an unknown data word changes none of protect_on, id_mode or erase_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address for identification reads |
| wr_permit | output | 1 | The current strobe may load the page buffer |
| protect_on | output | 1 | Write protection armed |
| id_mode | output | 1 | Identification read mode active |
| erase_req | output | 1 | One-cycle whole-array erase request |
| id_rdata | output | DATA_W | Identification word for rd_addr |

## Verification
The hardest case to reach is the exact edge of the load-cycle timeout. A gap of TIMEOUT cycles must still count as in time, and one cycle more must abort the sequence or close the window. This happens in the middle of sequences that interleave with the protect and identification state. The stimulus table gives each write its own count of idle cycles. Entries placed right at the limit and one past it check that the window stays open and then closes, and that a late final step of a sequence is dropped.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int CMP_W = 15;

  localparam logic [CMP_W-1:0] A_ODD  = 15'h5555;
  localparam logic [CMP_W-1:0] A_EVEN = 15'h2AAA;

  localparam logic [15:0] D_KEY_A  = 16'hAAAA;
  localparam logic [15:0] D_KEY_B  = 16'h5555;
  localparam logic [15:0] D_ARM    = 16'hA0A0;
  localparam logic [15:0] D_EXTEND = 16'h8080;
  localparam logic [15:0] D_DISARM = 16'h2020;
  localparam logic [15:0] D_WIPE   = 16'h1010;
  localparam logic [15:0] D_IDLONG = 16'h6060;
  localparam logic [15:0] D_IDSHRT = 16'h9090;
  localparam logic [15:0] D_IDQUIT = 16'hF0F0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_X3, ST_X4, ST_X5
  } step_e;

  typedef struct packed {
    logic arm;
    logic disarm;
    logic wipe;
    logic id_in;
    logic id_out;
  } cmd_ev_t;

  function automatic logic key_a(input logic [CMP_W-1:0] a, input logic [15:0] d);
    return (a == A_ODD) && (d == D_KEY_A);
  endfunction

  function automatic logic key_b(input logic [CMP_W-1:0] a, input logic [15:0] d);
    return (a == A_EVEN) && (d == D_KEY_B);
  endfunction

  function automatic logic [15:0] id_word(input logic on, input logic [CMP_W-1:0] a,
                                          input logic [15:0] mfr, input logic [15:0] dev);
    if (!on)          return '0;
    if (a == 15'd0)   return mfr;
    if (a == 15'd1)   return dev;
    return '0;
  endfunction
endpackage

// File: rtl/useq_matcher.sv
module useq_matcher
  import useq_pkg::*;
#(
  parameter int TIMEOUT = 256,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [CMP_W-1:0]  addr,
  input  logic [DATA_W-1:0] data,
  output cmd_ev_t           ev,
  output logic              tmo_evt
);
  localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT - 1);

  step_e           step_q, step_d;
  logic [CNT_W-1:0] gap_q;
  logic            first_hit, second_hit, at_odd;
  step_e           restart;

  assign first_hit  = key_a(addr, data[15:0]);
  assign second_hit = key_b(addr, data[15:0]);
  assign at_odd     = (addr == A_ODD);
  assign restart    = first_hit ? ST_K1 : ST_IDLE;
  assign tmo_evt    = !stb && (gap_q == CNT_MAX);

  always_comb begin
    ev     = '0;
    step_d = step_q;
    if (stb) begin
      unique case (step_q)
        ST_IDLE: step_d = restart;
        ST_K1:   step_d = second_hit ? ST_K2 : restart;
        ST_K2: begin
          step_d = restart;
          if (at_odd) begin
            if (data[15:0] == D_ARM)         begin ev.arm    = 1'b1; step_d = ST_IDLE; end
            else if (data[15:0] == D_IDSHRT) begin ev.id_in  = 1'b1; step_d = ST_IDLE; end
            else if (data[15:0] == D_IDQUIT) begin ev.id_out = 1'b1; step_d = ST_IDLE; end
            else if (data[15:0] == D_EXTEND) step_d = ST_X3;
          end
        end
        ST_X3:   step_d = first_hit ? ST_X4 : ST_IDLE;
        ST_X4:   step_d = second_hit ? ST_X5 : restart;
        ST_X5: begin
          step_d = restart;
          if (at_odd) begin
            if (data[15:0] == D_DISARM)      begin ev.disarm = 1'b1; step_d = ST_IDLE; end
            else if (data[15:0] == D_WIPE)   begin ev.wipe   = 1'b1; step_d = ST_IDLE; end
            else if (data[15:0] == D_IDLONG) begin ev.id_in  = 1'b1; step_d = ST_IDLE; end
          end
        end
        default: step_d = ST_IDLE;
      endcase
    end else if (tmo_evt) begin
      step_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      gap_q  <= CNT_MAX;
    end else begin
      step_q <= step_d;
      if (stb)                  gap_q <= '0;
      else if (gap_q != CNT_MAX) gap_q <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/useq_modes.sv
module useq_modes
  import useq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  cmd_ev_t ev,
  input  logic    tmo_evt,
  output logic    protect_q,
  output logic    id_q,
  output logic    window_q,
  output logic    erase_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      protect_q <= 1'b1;
      id_q      <= 1'b0;
      window_q  <= 1'b0;
      erase_q   <= 1'b0;
    end else begin
      erase_q <= ev.wipe;
      if (ev.arm)         protect_q <= 1'b1;
      else if (ev.disarm) protect_q <= 1'b0;
      if (ev.id_in)       id_q <= 1'b1;
      else if (ev.id_out) id_q <= 1'b0;
      if (ev.arm)         window_q <= 1'b1;
      else if (tmo_evt)   window_q <= 1'b0;
    end
  end
endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
  import useq_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 16,
  parameter int          TIMEOUT  = 256,
  parameter logic [15:0] MFR_CODE = 16'h00DA,
  parameter logic [15:0] DEV_CODE = 16'h004F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              wr_permit,
  output logic              protect_on,
  output logic              id_mode,
  output logic              erase_req,
  output logic [DATA_W-1:0] id_rdata
);
  cmd_ev_t    ev;
  logic [4:0] ev_bits;
  logic       tmo_evt;
  logic       window_open;

  useq_matcher #(.TIMEOUT(TIMEOUT), .DATA_W(DATA_W)) u_match (
    .clk(clk), .rst_n(rst_n), .stb(wr_stb),
    .addr(wr_addr[CMP_W-1:0]), .data(wr_data),
    .ev(ev), .tmo_evt(tmo_evt)
  );

  useq_modes u_modes (
    .clk(clk), .rst_n(rst_n), .ev(ev), .tmo_evt(tmo_evt),
    .protect_q(protect_on), .id_q(id_mode),
    .window_q(window_open), .erase_q(erase_req)
  );

  assign ev_bits   = ev;
  assign wr_permit = wr_stb && (!protect_on || window_open);
  assign id_rdata  = DATA_W'(id_word(id_mode, rd_addr[CMP_W-1:0], MFR_CODE, DEV_CODE));
endmodule

// File: rtl/unlock_seq_decoder_chk.sv
module unlock_seq_decoder_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic              wr_permit,
  input logic              protect_on,
  input logic              id_mode,
  input logic              erase_req,
  input logic              window_open,
  input logic              tmo_evt,
  input logic [4:0]        ev_bits,
  input logic [DATA_W-1:0] id_rdata
);
  // ev_bits order: arm, disarm, wipe, id_in, id_out
  AST_ERASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req); // R6
  AST_ERASE_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> $past(ev_bits[2])); // R6
  AST_PROTECT_DROP_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(protect_on) |-> $past(ev_bits[3+1-1])); // R5
  AST_PERMIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_permit && protect_on) |-> window_open); // R3
  AST_WINDOW_FROM_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(window_open) |-> $past(ev_bits[4])); // R2
  AST_WINDOW_CLOSE_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(window_open) |-> $past(tmo_evt)); // R4
  AST_ID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !id_mode |-> (id_rdata == '0)); // R8
  AST_EV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_bits)); // R12
  AST_EV_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_bits) |-> wr_stb); // R10
  AST_ID_SET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(ev_bits[1])); // R7
endmodule

bind unlock_seq_decoder unlock_seq_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_permit(wr_permit),
  .protect_on(protect_on), .id_mode(id_mode), .erase_req(erase_req),
  .window_open(window_open), .tmo_evt(tmo_evt), .ev_bits(ev_bits),
  .id_rdata(id_rdata)
);

// File: tb/unlock_seq_decoder_test.sv
`timescale 1ns/1ps
module unlock_seq_decoder_test;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic        wr_permit, protect_on, id_mode, erase_req;
  logic [15:0] id_rdata;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  unlock_seq_decoder #(.TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .wr_permit(wr_permit),
    .protect_on(protect_on), .id_mode(id_mode), .erase_req(erase_req),
    .id_rdata(id_rdata)
  );

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] d;
    logic [4:0]  gap;
    logic        perm;
    logic        prot;
    logic        id;
    logic        ers;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VEC [NV] = '{
    '{16'h0100, 16'h1234, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 no window
    '{16'h5555, 16'hAAAA, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd2},  // R2
    '{16'h2AAA, 16'h5555, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd2},
    '{16'h5555, 16'hA0A0, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd2},
    '{16'h0080, 16'h1111, 5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 4'd2},
    '{16'h0081, 16'h2222, 5'd14, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 gap = TMO
    '{16'h0082, 16'h3333, 5'd15, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 gap = TMO+1
    '{16'h5555, 16'hAAAA, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
    '{16'h2AAA, 16'h5555, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd5},
    '{16'h5555, 16'h8080, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd5},
    '{16'h5555, 16'hAAAA, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd5},
    '{16'h2AAA, 16'h5555, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd5},
    '{16'h5555, 16'h2020, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 4'd5},
    '{16'h0200, 16'h4444, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 4'd5},
    '{16'h5555, 16'hAAAA, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    '{16'h2AAA, 16'h5555, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 4'd6},
    '{16'h5555, 16'h8080, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 4'd6},
    '{16'h5555, 16'hAAAA, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 4'd6},
    '{16'h2AAA, 16'h5555, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 4'd6},
    '{16'h5555, 16'h1010, 5'd0,  1'b1, 1'b0, 1'b0, 1'b1, 4'd6},
    '{16'h5555, 16'hAAAA, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 short entry
    '{16'h2AAA, 16'h5555, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 4'd7},
    '{16'h5555, 16'h9090, 5'd0,  1'b1, 1'b0, 1'b1, 1'b0, 4'd7},
    '{16'h5555, 16'hAAAA, 5'd0,  1'b1, 1'b0, 1'b1, 1'b0, 4'd7},  // R7 exit
    '{16'h2AAA, 16'h5555, 5'd0,  1'b1, 1'b0, 1'b1, 1'b0, 4'd7},
    '{16'h5555, 16'hF0F0, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 4'd7},
    '{16'h5555, 16'hAAAA, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 repeat
    '{16'h5555, 16'hAAAA, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 4'd10},
    '{16'h2AAA, 16'h5555, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 4'd10},
    '{16'h5555, 16'hA0A0, 5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 4'd10},
    '{16'h0300, 16'h5555, 5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 4'd2},
    '{16'hD555, 16'hAAAA, 5'd15, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9},  // R9 bit 15 set
    '{16'hAAAA, 16'h5555, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd9},
    '{16'h5555, 16'h8080, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd9},
    '{16'h5555, 16'hAAAA, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd9},
    '{16'h2AAA, 16'h5555, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd9},
    '{16'hD555, 16'h6060, 5'd0,  1'b0, 1'b1, 1'b1, 1'b0, 4'd9},
    '{16'h5555, 16'hAAAA, 5'd0,  1'b0, 1'b1, 1'b1, 1'b0, 4'd11}, // R11 late step
    '{16'h2AAA, 16'h5555, 5'd0,  1'b0, 1'b1, 1'b1, 1'b0, 4'd11},
    '{16'h5555, 16'hF0F0, 5'd15, 1'b0, 1'b1, 1'b1, 1'b0, 4'd11},
    '{16'h5555, 16'hAAAA, 5'd0,  1'b0, 1'b1, 1'b1, 1'b0, 4'd12}, // R12 bad tail
    '{16'h2AAA, 16'h5555, 5'd0,  1'b0, 1'b1, 1'b1, 1'b0, 4'd12},
    '{16'h5555, 16'h1234, 5'd0,  1'b0, 1'b1, 1'b1, 1'b0, 4'd12},
    '{16'h5555, 16'hAAAA, 5'd0,  1'b0, 1'b1, 1'b1, 1'b0, 4'd7},
    '{16'h2AAA, 16'h5555, 5'd0,  1'b0, 1'b1, 1'b1, 1'b0, 4'd7},
    '{16'h5555, 16'hF0F0, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd7}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d,
                          input int gap, output logic perm);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    #1 perm = wr_permit;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic p;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 protect", {15'd0, protect_on}, 16'd1);
    check("R1 id", {15'd0, id_mode}, 16'd0);
    check("R1 erase", {15'd0, erase_req}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 protect after release", {15'd0, protect_on}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i].a, VEC[i].d, int'(VEC[i].gap), p);
      check($sformatf("R%0d permit #%0d", VEC[i].req, i), {15'd0, p}, {15'd0, VEC[i].perm});
      check($sformatf("R%0d protect #%0d", VEC[i].req, i), {15'd0, protect_on}, {15'd0, VEC[i].prot});
      check($sformatf("R%0d id #%0d", VEC[i].req, i), {15'd0, id_mode}, {15'd0, VEC[i].id});
      check($sformatf("R%0d erase #%0d", VEC[i].req, i), {15'd0, erase_req}, {15'd0, VEC[i].ers});
      if (VEC[i].ers) begin
        @(negedge clk);
        check("R6 erase width", {15'd0, erase_req}, 16'd0);
      end
    end

    // R8 identification reads
    do_write(16'h5555, 16'hAAAA, 0, p);
    do_write(16'h2AAA, 16'h5555, 0, p);
    do_write(16'h5555, 16'h9090, 0, p);
    rd_addr = 16'h0000; #1 check("R8 maker code", id_rdata, 16'h00DA);
    rd_addr = 16'h0001; #1 check("R8 part code", id_rdata, 16'h004F);
    rd_addr = 16'h0002; #1 check("R8 other addr", id_rdata, 16'h0000);
    rd_addr = 16'h8001; #1 check("R8 high bit ignored", id_rdata, 16'h004F);

    // R1 reset mid-run clears id mode, rearms protect
    do_write(16'h5555, 16'hAAAA, 0, p);
    do_write(16'h2AAA, 16'h5555, 0, p);
    do_write(16'h5555, 16'h8080, 0, p);
    do_write(16'h5555, 16'hAAAA, 0, p);
    do_write(16'h2AAA, 16'h5555, 0, p);
    do_write(16'h5555, 16'h2020, 0, p);
    check("R5 protect off before reset", {15'd0, protect_on}, 16'd0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 protect rearmed", {15'd0, protect_on}, 16'd1);
    check("R1 id cleared", {15'd0, id_mode}, 16'd0);
    rd_addr = 16'h0000; #1 check("R8 no id after reset", id_rdata, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    // R1 matcher idle: tail writes alone do nothing
    do_write(16'h2AAA, 16'h5555, 0, p);
    do_write(16'h5555, 16'h9090, 0, p);
    check("R1 matcher idle", {15'd0, id_mode}, 16'd0);
    check("R3 gated", {15'd0, p}, 16'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule